// File: doc/BRIEF.md
# Unaligned Streaming Row Load Unit

This unit returns 512-bit vectors that start at any byte address, from a memory that can only hand back whole 64-byte rows. It keeps four alignment registers. Each one holds the most recently fetched row of one stream, together with the byte offset of that stream. A stream begins with a prime command, which fetches the first row and records the address modulo 64. After that, every use command fetches the following row and returns one 64-byte window cut from the pair {held row, new row}. The new row then becomes the held row, so each command produces exactly one unaligned vector.

Two commands work on the registers without touching memory. A zero command clears a register, which starts a stream that is row-aligned. A move command copies a register, with its offset and valid flag, into another register so that a second stream can continue from the state of the first. Commands are accepted only while the unit is idle, and at most one row read is outstanding at a time. A use of a register that was never primed is held off at the command port.

Top module: `ualign_stream_ld`

## Requirements
- R1: The unit holds four independent alignment registers, chosen by the 2-bit `cmd_dst` index. A command on one register leaves the data and offset of every other register unchanged.
- R2: Each row fetch drives `mem_addr` equal to the command address with bits [5:0] cleared. A misaligned address is floored to its row and causes no error.
- R3: A use command returns, as `res_data` byte j (bits 8j+7..8j), byte (k + j) of the 128-byte concatenation formed by the stored row (bytes 0..63) and the fetched row (bytes 64..127). Here k is the offset stored in the register and j runs from 0 to 63.
- R4: With a stored offset of 63, result byte 0 is the last stored byte and bytes 1..63 are fetched bytes 0..62. With a stored offset of 0, the result equals the stored row.
- R5: After a use command returns its result, the register holds the fetched row. The next use command on that register therefore merges against that row.
- R6: A prime command (`cmd_op` = 0) fetches one row into the register, stores the command address modulo 64 as the register's offset, and never raises `res_valid`.
- R7: A zero command (`cmd_op` = 1) sets the register's data and offset to zero and marks it valid, with no row fetch.
- R8: A move command (`cmd_op` = 2) copies the data, offset and valid flag of register `cmd_src` into register `cmd_dst`, with no row fetch.
- R9: A use command (`cmd_op` = 3) on a register that is not valid keeps `cmd_ready` low and issues no fetch for as long as it is presented.
- R10: `mem_req` is a one-cycle pulse, and only one read is outstanding at a time. `cmd_ready` stays low from the acceptance of a fetching command until its read data has returned. `res_valid` is a one-cycle pulse.
- R11: Reset clears every register, every offset and every valid flag, and drops `mem_req` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high together with `cmd_valid` |
| cmd_op | input | 2 | 0 prime, 1 zero, 2 move, 3 use |
| cmd_dst | input | 2 | Target alignment register |
| cmd_src | input | 2 | Source register for move |
| cmd_addr | input | 32 | Byte address for prime and use |
| mem_req | output | 1 | One-cycle row read request |
| mem_addr | output | 32 | Row-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 512 | Row read data, byte 0 in bits 7..0 |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 512 | Unaligned vector |

## Verification
The hardest conditions to reach are the ones where the stored offset and the register's history interact: offset 63 crossing the row boundary, a register whose carry was replaced by an earlier use, and a register built by a move from another stream. The stimulus primes streams at chosen byte offsets and chains use commands on the same register. It zeroes a register and copies one register into another before each is used, and it interleaves two streams so that any cross-talk would show up. Memory latency is varied so that the held-off command port is exercised for different lengths of time, and an unprimed use is presented for several cycles, with a reset between a prime and its use.

// File: rtl/ualign_stream_ld.sv
module ualign_stream_ld #(
  parameter int ROW_BYTES = 64,
  parameter int NREG      = 4,
  parameter int ADDR_W    = 32,
  localparam int ROW_W    = ROW_BYTES * 8,
  localparam int OFF_W    = $clog2(ROW_BYTES),
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_dst,
  input  logic [IDX_W-1:0]  cmd_src,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ROW_W-1:0]  mem_rdata,
  output logic              res_valid,
  output logic [ROW_W-1:0]  res_data
);
  localparam logic [1:0] OP_PRIME = 2'd0, OP_ZERO = 2'd1, OP_MOVE = 2'd2, OP_USE = 2'd3;

  logic [ROW_W-1:0] carry [NREG];
  logic [OFF_W-1:0] off   [NREG];
  logic [NREG-1:0]  vld;
  logic             busy;
  logic [1:0]       pend_op;
  logic [IDX_W-1:0] pend_idx;
  logic [OFF_W-1:0] pend_off;

  wire unprimed = (cmd_op == OP_USE) && !vld[cmd_dst];
  assign cmd_ready = !busy && !unprimed;
  wire take = cmd_valid && cmd_ready;
  wire done = busy && mem_rvalid;

  wire [2*ROW_W-1:0] pair    = {mem_rdata, carry[pend_idx]};
  wire [2*ROW_W-1:0] shifted = pair >> {off[pend_idx], 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        carry[i] <= '0;
        off[i]   <= '0;
      end
      vld       <= '0;
      busy      <= 1'b0;
      pend_op   <= OP_PRIME;
      pend_idx  <= '0;
      pend_off  <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      mem_req   <= 1'b0;
      res_valid <= 1'b0;
      if (take) begin
        case (cmd_op)
          OP_ZERO: begin
            carry[cmd_dst] <= '0;
            off[cmd_dst]   <= '0;
            vld[cmd_dst]   <= 1'b1;
          end
          OP_MOVE: begin
            carry[cmd_dst] <= carry[cmd_src];
            off[cmd_dst]   <= off[cmd_src];
            vld[cmd_dst]   <= vld[cmd_src];
          end
          default: begin
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_addr <= {cmd_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            pend_op  <= cmd_op;
            pend_idx <= cmd_dst;
            pend_off <= cmd_addr[OFF_W-1:0];
          end
        endcase
      end
      if (done) begin
        busy            <= 1'b0;
        carry[pend_idx] <= mem_rdata;
        vld[pend_idx]   <= 1'b1;
        if (pend_op == OP_PRIME) begin
          off[pend_idx] <= pend_off;
        end else begin
          res_valid <= 1'b1;
          res_data  <= shifted[ROW_W-1:0];
        end
      end
    end
  end

  a_r10_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && !cmd_ready);
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r10_res_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r2_row_floor: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[OFF_W-1:0] == '0);
  a_r9_fetch_only_primed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && pend_op == OP_USE) |-> vld[pend_idx]);
  a_r5_carry_takes_row: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> carry[pend_idx] == $past(mem_rdata));
  a_r6_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pend_op == OP_PRIME) |=> !res_valid);
  a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_ZERO) |=> !mem_req && carry[$past(cmd_dst)] == '0 && off[$past(cmd_dst)] == '0);
endmodule

// File: tb/sim_ualign_stream_ld.sv
`timescale 1ns/1ps
module sim_ualign_stream_ld;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0, cmd_dst = 2'd0, cmd_src = 2'd0;
  logic [31:0] cmd_addr = '0;
  logic mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr;
  logic [511:0] mem_rdata = '0;
  logic res_valid;
  logic [511:0] res_data;

  ualign_stream_ld u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_addr(cmd_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_data(res_data)
  );

  int checks = 0, errors = 0, cycles = 0, lat = 1, pend = 0;
  logic [31:0] seen_addr = '0, exp_fetch = '0;
  bit expect_res = 0;
  logic [511:0] ref_c [4];
  logic [5:0]   ref_o [4];
  bit           ref_v [4];

  function automatic logic [511:0] row_of(input logic [31:0] a);
    logic [511:0] r;
    for (int i = 0; i < 64; i++) r[i*8 +: 8] = 8'((a >> 6) * 29 + i * 7 + 3);
    return r;
  endfunction

  function automatic logic [511:0] win(input logic [511:0] c, input logic [511:0] n, input logic [5:0] o);
    logic [511:0] r;
    for (int j = 0; j < 64; j++) begin
      int k = int'(o) + j;
      r[j*8 +: 8] = (k < 64) ? c[k*8 +: 8] : n[(k-64)*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (!rst_n) pend = 0;
    else begin
      if (pend == 1) begin
        mem_rvalid = 1'b1;
        mem_rdata  = row_of(seen_addr);
      end
      if (pend > 0) pend--;
      if (mem_req) begin
        chk(mem_addr == exp_fetch, "R2 fetch address", 512'(mem_addr), 512'(exp_fetch));
        pend = lat;
        seen_addr = mem_addr;
      end
    end
  end

  always @(negedge clk)
    if (rst_n && res_valid && !expect_res)
      chk(1'b0, "R6 unexpected result", 512'(res_valid), 512'(0));

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin ref_c[i] = '0; ref_o[i] = '0; ref_v[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] d, input logic [1:0] s,
                       input logic [31:0] a, input string tag);
    logic [511:0] exp;
    int n;
    exp_fetch = a & ~32'h3f;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dst = d; cmd_src = s; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    case (op)
      2'd1: begin
        chk(!mem_req, {tag, " zero without fetch"}, 512'(mem_req), 512'(0));
        ref_c[d] = '0; ref_o[d] = '0; ref_v[d] = 1;
      end
      2'd2: begin
        chk(!mem_req, {tag, " move without fetch"}, 512'(mem_req), 512'(0));
        ref_c[d] = ref_c[s]; ref_o[d] = ref_o[s]; ref_v[d] = ref_v[s];
      end
      2'd0: begin
        chk(!cmd_ready, {tag, " busy during prime"}, 512'(cmd_ready), 512'(0));
        n = 0;
        while (!cmd_ready && n < 20) begin @(negedge clk); n++; end
        ref_c[d] = row_of(a); ref_o[d] = a[5:0]; ref_v[d] = 1;
      end
      default: begin
        expect_res = 1;
        exp = win(ref_c[d], row_of(a), ref_o[d]);
        chk(!cmd_ready, {tag, " busy during use"}, 512'(cmd_ready), 512'(0));
        n = 0;
        while (!res_valid && n < 20) begin @(negedge clk); n++; end
        chk(res_valid && res_data == exp, tag, res_data, exp);
        @(negedge clk);
        chk(!res_valid, "R10 result pulse", 512'(res_valid), 512'(0));
        expect_res = 0;
        ref_c[d] = row_of(a);
      end
    endcase
  endtask

  task automatic expect_stall(input logic [1:0] d, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_dst = d; cmd_addr = 32'h8000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!cmd_ready && !mem_req, tag, 512'({cmd_ready, mem_req}), 512'(0));
    end
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  logic [511:0] tmp;

  initial begin
    model_reset();
    do_reset();
    chk(!res_valid && !mem_req && cmd_ready, "R11 reset state",
        512'({res_valid, mem_req, cmd_ready}), 512'(1));
    expect_stall(2'd2, "R9 unprimed use held off");
    expect_stall(2'd0, "R11 registers invalid after reset");

    issue(2'd0, 2'd0, 2'd0, 32'h1005, "R6 prime");
    issue(2'd3, 2'd0, 2'd0, 32'h1040, "R3 window offset 5");
    lat = 2;
    issue(2'd3, 2'd0, 2'd0, 32'h1080, "R5 carry replaced");
    issue(2'd3, 2'd0, 2'd0, 32'h10DD, "R2 misaligned use floored");

    lat = 3;
    issue(2'd0, 2'd1, 2'd0, 32'h207F, "R6 prime offset 63");
    issue(2'd3, 2'd1, 2'd0, 32'h20C0, "R4 offset 63");
    tmp = row_of(32'h2040);
    chk(res_data[7:0] == tmp[511:504], "R4 byte0 is last carry byte",
        512'(res_data[7:0]), 512'(tmp[511:504]));
    tmp = row_of(32'h20C0);
    chk(res_data[15:8] == tmp[7:0], "R4 byte1 is new byte0",
        512'(res_data[15:8]), 512'(tmp[7:0]));

    lat = 1;
    issue(2'd0, 2'd2, 2'd0, 32'h3000, "R6 prime offset 0");
    tmp = row_of(32'h3000);
    issue(2'd3, 2'd2, 2'd0, 32'h3040, "R4 offset 0");
    chk(res_data == tmp, "R4 offset 0 equals carry", res_data, tmp);

    issue(2'd1, 2'd3, 2'd0, 32'h0, "R7");
    issue(2'd3, 2'd3, 2'd0, 32'h4000, "R7 zeroed register yields zeros");
    chk(res_data == '0, "R7 zero output", res_data, '0);

    issue(2'd2, 2'd3, 2'd1, 32'h0, "R8");
    issue(2'd3, 2'd3, 2'd0, 32'h5000, "R8 moved register window");
    issue(2'd3, 2'd1, 2'd0, 32'h6000, "R1 source unaffected by copy use");

    lat = 2;
    issue(2'd3, 2'd0, 2'd0, 32'h7000, "R1 stream 0 interleave");
    issue(2'd3, 2'd2, 2'd0, 32'h7040, "R1 stream 2 interleave");
    issue(2'd3, 2'd0, 2'd0, 32'h7080, "R1 stream 0 resumes");

    issue(2'd0, 2'd0, 2'd0, 32'h9011, "R6 prime before reset");
    do_reset();
    expect_stall(2'd0, "R11 primed register cleared by reset");

    summary();
    $finish;
  end
endmodule